// File: doc/BRIEF.md
# Multi-Master Cache Maintenance Command Queue

This block is the register front-end of a cache-maintenance engine that several CPUs share. Masters reach it over a simple register bus that carries a master ID. A master builds one command in a shared staging area made of a mode word, a start address, a size and a way mask. It then reads its registration-result register to find out whether the command was accepted.

Writing the mode word takes an implicit hardware lock, so the build of each command is atomic. Reading the result register releases the lock. If the queue has room, that same read commits the command to a small FIFO. A stub executor takes commands from the FIFO one at a time. Each command keeps the executor busy for a fixed, parameterised number of cycles. Every master has its own result and status copies, so it only ever sees the outcome of its own commands.

A sync primitive lets a master wait until all queued work has drained. The wait is a bus read that stalls until the drain is complete.

Top module: `mq_cmd_queue`

## Requirements
- R1: A mode write (offset 0x248) while the lock is free gives the lock to the writing master. A mode write from another master while the lock is held fails, and that master's next result read (0x25C) returns 0x1 (bit 0, ownership failure).
- R2: Writes from a non-owner to mode, address (0x24C), size (0x250) or way (0x258) leave the staged command unchanged.
- R3: When the owner reads the result register and the FIFO has room, the read returns 0, commits the staged command and releases the lock.
- R4: When the owner reads the result register and the FIFO is full, the read returns 0x2 (bit 1, queue full), commits nothing and still releases the lock.
- R5: Committed commands reach the dispatch port in commit order, one per executor slot, each dispatched exactly once.
- R6: Bit 0 of a master's status register (0x260) is 1 while that master has commands that are queued or executing, and 0 otherwise.
- R7: Status bit 2 is set when a command with mode bit 15 (notify) finishes, and is set for the issuing master only. Status bit 1 is set by any failed registration. Writing 1 to bit 2 or to bit 1 clears that bit.
- R8: Result and status state is kept per master. One master's failures and completions never show in another master's registers.
- R9: After a write of 0x8 to offset 0x244, a read of 0x244 holds bus_ready_o low until the FIFO is empty and the executor is idle, then returns 0.
- R10: After reset the lock is free, the FIFO is empty, every status reads 0, bus_ready_o is 1 and disp_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access request, held until ready |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_mid_i | input | 4 | Master ID of the access |
| bus_ready_o | output | 1 | Access completes on this clock edge |
| bus_rdata_o | output | 32 | Read data, valid while ready is high |
| disp_valid_o | output | 1 | One-cycle pulse: a command is handed to the executor |
| disp_mid_o | output | 4 | Issuing master of the dispatched command |
| disp_mode_o | output | 32 | Mode word of the dispatched command |
| disp_addr_o | output | 32 | Start address of the dispatched command |
| disp_size_o | output | 32 | Size of the dispatched command |
| disp_way_o | output | 32 | Way mask of the dispatched command |

## Verification
Each kind of wrong internal state has a visible effect at the ports:

- **Lock owner is wrong.** A competing master's staging write reaches the dispatch port, or the owner's command loses its notify bit. The second case shows up as a missing completion flag about one executor latency after the commit.
- **FIFO pointer or count is wrong.** Dispatched addresses come out lost, duplicated or reordered, or a full-queue registration returns 0 instead of 0x2 on the very read that should fail.
- **Per-master pending count is wrong.** The busy bit stays stuck after the drain.
- **Sync drain check is wrong.** The sync read returns before the last dispatched command has retired.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int MID_W = 4;

  localparam logic [11:0] OFS_PRIM = 12'h244;
  localparam logic [11:0] OFS_MODE = 12'h248;
  localparam logic [11:0] OFS_ADDR = 12'h24C;
  localparam logic [11:0] OFS_SIZE = 12'h250;
  localparam logic [11:0] OFS_WAY  = 12'h258;
  localparam logic [11:0] OFS_RES  = 12'h25C;
  localparam logic [11:0] OFS_STAT = 12'h260;

  localparam logic [31:0] PRIM_SYNC = 32'h8;
  localparam int NOTIFY_BIT = 15;

  typedef struct packed {
    logic [MID_W-1:0] mid;
    logic [31:0]      mode;
    logic [31:0]      addr;
    logic [31:0]      size;
    logic [31:0]      way;
  } cmd_t;
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/mq_exec.sv
module mq_exec #(
  parameter int EXEC_LAT = 8,
  parameter int MID_W    = 4,
  localparam int LAT_W   = $clog2(EXEC_LAT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [MID_W-1:0] cmd_mid_i,
  input  logic             cmd_notify_i,
  output logic             pop_o,
  output logic             idle_o,
  output logic             done_o,
  output logic [MID_W-1:0] done_mid_o,
  output logic             done_notify_o
);
  logic             busy_q;
  logic [LAT_W-1:0] cnt_q;
  logic [MID_W-1:0] mid_q;
  logic             notify_q;

  assign pop_o         = cmd_valid_i && !busy_q;
  assign idle_o        = !busy_q;
  assign done_o        = busy_q && (cnt_q == '0);
  assign done_mid_o    = mid_q;
  assign done_notify_o = notify_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      mid_q    <= '0;
      notify_q <= 1'b0;
    end else if (pop_o) begin
      busy_q   <= 1'b1;
      cnt_q    <= LAT_W'(EXEC_LAT - 1);
      mid_q    <= cmd_mid_i;
      notify_q <= cmd_notify_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assert_hold_until_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && $stable(mid_q)));
endmodule

// File: rtl/mq_cmd_queue.sv
module mq_cmd_queue
  import mq_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int FIFO_DEPTH  = 2,
  parameter int EXEC_LAT    = 8,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  input  logic [MID_W-1:0] bus_mid_i,
  output logic             bus_ready_o,
  output logic [31:0]      bus_rdata_o,
  output logic             disp_valid_o,
  output logic [MID_W-1:0] disp_mid_o,
  output logic [31:0]      disp_mode_o,
  output logic [31:0]      disp_addr_o,
  output logic [31:0]      disp_size_o,
  output logic [31:0]      disp_way_o
);
  // staging area and lock
  logic             lock_q;
  logic [MID_W-1:0] owner_q;
  logic [31:0]      mode_q, addr_q, size_q, way_q;
  logic             sync_q;

  logic [NUM_MASTERS-1:0] oe_q, err_q, ef_q;
  logic [CNT_W-1:0]       pend_q [NUM_MASTERS];

  logic fifo_empty, fifo_full, fifo_pop;
  logic exec_idle, exec_done, exec_notify;
  logic [MID_W-1:0] exec_mid;
  cmd_t head, staged;

  logic mid_ok, acc, wr, rd, is_owner, take, deny, own_wr;
  logic res_rd, commit, reject_full, release_lk, drained, prim_rd;

  assign mid_ok   = int'(bus_mid_i) < NUM_MASTERS;
  assign drained  = fifo_empty && exec_idle;
  assign prim_rd  = bus_req_i && !bus_we_i && (bus_addr_i == OFS_PRIM);
  assign bus_ready_o = !(prim_rd && sync_q && !drained);

  assign acc      = bus_req_i && bus_ready_o && mid_ok;
  assign wr       = acc && bus_we_i;
  assign rd       = acc && !bus_we_i;
  assign is_owner = lock_q && (owner_q == bus_mid_i);
  assign take     = wr && (bus_addr_i == OFS_MODE) && !lock_q;
  assign deny     = wr && (bus_addr_i == OFS_MODE) && lock_q && !is_owner;
  assign own_wr   = wr && is_owner;
  assign res_rd   = rd && (bus_addr_i == OFS_RES);
  assign commit      = res_rd && is_owner && !fifo_full;
  assign reject_full = res_rd && is_owner && fifo_full;
  assign release_lk  = res_rd && is_owner;

  assign staged = '{mid: owner_q, mode: mode_q, addr: addr_q, size: size_q, way: way_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      mode_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
      way_q   <= '0;
      sync_q  <= 1'b0;
    end else begin
      if (take) begin
        lock_q  <= 1'b1;
        owner_q <= bus_mid_i;
        mode_q  <= bus_wdata_i;
      end else if (own_wr) begin
        unique case (bus_addr_i)
          OFS_MODE: mode_q <= bus_wdata_i;
          OFS_ADDR: addr_q <= bus_wdata_i;
          OFS_SIZE: size_q <= bus_wdata_i;
          OFS_WAY:  way_q  <= bus_wdata_i;
          default: ;
        endcase
      end
      if (release_lk) lock_q <= 1'b0;
      if (wr && bus_addr_i == OFS_PRIM && bus_wdata_i == PRIM_SYNC) sync_q <= 1'b1;
      else if (rd && bus_addr_i == OFS_PRIM) sync_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_mst
    logic hit;
    assign hit = (bus_mid_i == MID_W'(g));
    logic dn;
    assign dn = exec_done && (exec_mid == MID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        oe_q[g]   <= 1'b0;
        err_q[g]  <= 1'b0;
        ef_q[g]   <= 1'b0;
        pend_q[g] <= '0;
      end else begin
        if (hit && deny) oe_q[g] <= 1'b1;
        else if (hit && res_rd && !is_owner) oe_q[g] <= 1'b0;

        if (hit && (deny || reject_full)) err_q[g] <= 1'b1;
        else if (hit && wr && bus_addr_i == OFS_STAT && bus_wdata_i[1]) err_q[g] <= 1'b0;

        if (dn && exec_notify) ef_q[g] <= 1'b1;
        else if (hit && wr && bus_addr_i == OFS_STAT && bus_wdata_i[2]) ef_q[g] <= 1'b0;

        pend_q[g] <= pend_q[g] + CNT_W'(hit && commit) - CNT_W'(dn);
      end
    end

    assert_done_has_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dn |-> (pend_q[g] != '0));
  end

  always_comb begin
    logic s_oe, s_err, s_ef, s_busy;
    s_oe = 1'b0; s_err = 1'b0; s_ef = 1'b0; s_busy = 1'b0;
    for (int m = 0; m < NUM_MASTERS; m++) begin
      if (bus_mid_i == MID_W'(m)) begin
        s_oe   = oe_q[m];
        s_err  = err_q[m];
        s_ef   = ef_q[m];
        s_busy = (pend_q[m] != '0);
      end
    end
    bus_rdata_o = '0;
    if (bus_addr_i == OFS_RES)
      bus_rdata_o = is_owner ? {30'b0, fifo_full, 1'b0} : {31'b0, s_oe};
    else if (bus_addr_i == OFS_STAT)
      bus_rdata_o = {29'b0, s_ef, s_err, s_busy};
  end

  mq_fifo #(.W($bits(cmd_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (commit),
    .din_i   (staged),
    .pop_i   (fifo_pop),
    .dout_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  mq_exec #(.EXEC_LAT(EXEC_LAT), .MID_W(MID_W)) u_exec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (!fifo_empty),
    .cmd_mid_i     (head.mid),
    .cmd_notify_i  (head.mode[NOTIFY_BIT]),
    .pop_o         (fifo_pop),
    .idle_o        (exec_idle),
    .done_o        (exec_done),
    .done_mid_o    (exec_mid),
    .done_notify_o (exec_notify)
  );

  assign disp_valid_o = fifo_pop;
  assign disp_mid_o   = head.mid;
  assign disp_mode_o  = head.mode;
  assign disp_addr_o  = head.addr;
  assign disp_size_o  = head.size;
  assign disp_way_o   = head.way;

  assert_lock_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !release_lk) |=> (lock_q && $stable(owner_q)));
  assert_staging_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !(bus_req_i && bus_we_i && bus_mid_i == owner_q)) |=> $stable(addr_q));
  assert_sync_drained_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prim_rd && sync_q && bus_ready_o) |-> (fifo_empty && exec_idle));
endmodule

// File: tb/tb_mq_cmd_queue.sv
module tb_mq_cmd_queue;
  localparam int LAT = 40;
  localparam int NV  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  mid = '0;
  logic        ready, dvalid;
  logic [31:0] rdata, dmode, daddr, dsize, dway;
  logic [3:0]  dmid;

  int total = 0, fails = 0;
  int disp_n = 0;
  logic [31:0] disp_log [16];

  always #10 clk = ~clk;

  mq_cmd_queue #(.NUM_MASTERS(4), .FIFO_DEPTH(2), .EXEC_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_mid_i(mid),
    .bus_ready_o(ready), .bus_rdata_o(rdata), .disp_valid_o(dvalid),
    .disp_mid_o(dmid), .disp_mode_o(dmode), .disp_addr_o(daddr),
    .disp_size_o(dsize), .disp_way_o(dway));

  always @(negedge clk) begin
    if (rst_n && dvalid && disp_n < 16) begin
      disp_log[disp_n] = daddr;
      disp_n++;
    end
  end

  // fields: mid[89:86] we[85] addr[84:73] wdata[72:41] exp[40:9] chk[8] idle[7:0]
  localparam logic [89:0] VEC [NV] = '{
    {4'd0, 1'b1, 12'h248, 32'h0000_8002, 32'h0, 1'b0, 8'd0},  // m0 locks, flush+notify
    {4'd0, 1'b1, 12'h24C, 32'h0000_1000, 32'h0, 1'b0, 8'd0},
    {4'd0, 1'b1, 12'h250, 32'h0000_0040, 32'h0, 1'b0, 8'd0},
    {4'd1, 1'b1, 12'h248, 32'h0000_0001, 32'h0, 1'b0, 8'd0},  // R1 denied
    {4'd1, 1'b1, 12'h24C, 32'h0000_DEAD, 32'h0, 1'b0, 8'd0},  // R2 ignored
    {4'd1, 1'b0, 12'h25C, 32'h0,         32'h1, 1'b1, 8'd0},  // R1 OE
    {4'd0, 1'b0, 12'h25C, 32'h0,         32'h0, 1'b1, 8'd0},  // R3 commit
    {4'd0, 1'b0, 12'h260, 32'h0,         32'h1, 1'b1, 8'd80}, // R6 busy
    {4'd0, 1'b0, 12'h260, 32'h0,         32'h4, 1'b1, 8'd0},  // R7 EF
    {4'd1, 1'b0, 12'h260, 32'h0,         32'h2, 1'b1, 8'd0},  // R8 isolation
    {4'd0, 1'b1, 12'h260, 32'h4,         32'h0, 1'b0, 8'd0},
    {4'd0, 1'b0, 12'h260, 32'h0,         32'h0, 1'b1, 8'd0},  // R7 EF cleared
    {4'd1, 1'b1, 12'h260, 32'h2,         32'h0, 1'b0, 8'd0},
    {4'd1, 1'b0, 12'h260, 32'h0,         32'h0, 1'b1, 8'd0}   // R7 err cleared
  };
  string row_tag [NV] = '{"R1","R1","R1","R1","R2","R1","R3","R6","R7","R8","R7","R7","R7","R7"};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic [3:0] m, input logic w, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] r, output int stall);
    stall = 0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; mid = m;
    forever begin
      #5;
      if (ready) break;
      stall++;
      @(negedge clk);
    end
    r = rdata;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic issue(input logic [3:0] m, input logic [31:0] a, output logic [31:0] res);
    int s;
    logic [31:0] r;
    bus(m, 1'b1, 12'h248, 32'h0000_0001, r, s);
    bus(m, 1'b1, 12'h24C, a, r, s);
    bus(m, 1'b0, 12'h25C, 32'h0, res, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset state
    #5;
    check({31'b0, ready}, 32'h1, "R10 ready");
    check({31'b0, dvalid}, 32'h0, "R10 dispatch");
    bus(4'd0, 1'b0, 12'h260, 32'h0, r, s);
    check(r, 32'h0, "R10 status");

    for (int i = 0; i < NV; i++) begin
      logic [89:0] v;
      v = VEC[i];
      bus(v[89:86], v[85], v[84:73], v[72:41], r, s);
      if (v[8]) check(r, v[40:9], row_tag[i]);
      repeat (int'(v[7:0])) @(posedge clk);
    end
    // R2: competing address write must not reach the dispatched command
    check(32'(disp_n), 32'd1, "R2 count");
    check(disp_log[0], 32'h1000, "R2 addr");

    // R4: fill queue (one executing + two queued), fourth fails
    issue(4'd2, 32'hA000, r); check(r, 32'h0, "R3 A");
    issue(4'd2, 32'hB000, r); check(r, 32'h0, "R3 B");
    issue(4'd2, 32'hC000, r); check(r, 32'h0, "R3 C");
    issue(4'd2, 32'hD000, r); check(r, 32'h2, "R4 full");
    bus(4'd2, 1'b0, 12'h260, 32'h0, r, s);
    check(r, 32'h3, "R6 busy and R4 err");
    // lock released after failed registration: m3 may take it
    issue(4'd3, 32'hE000, r); check(r, 32'h2, "R4 release");

    // R9 sync drain
    bus(4'd3, 1'b1, 12'h244, 32'h8, r, s);
    bus(4'd3, 1'b0, 12'h244, 32'h0, r, s);
    check(r, 32'h0, "R9 rdata");
    check(32'(s > LAT), 32'h1, "R9 stalled");
    check(32'(disp_n), 32'd4, "R5 dispatch count");
    check(disp_log[1], 32'hA000, "R5 order 1");
    check(disp_log[2], 32'hB000, "R5 order 2");
    check(disp_log[3], 32'hC000, "R5 order 3");
    bus(4'd2, 1'b0, 12'h260, 32'h0, r, s);
    check(r, 32'h2, "R7 no EF without notify, R6 idle");
    bus(4'd0, 1'b0, 12'h260, 32'h0, r, s);
    check(r, 32'h0, "R8 m0 untouched");
    // R9 read without pending sync does not stall
    bus(4'd3, 1'b0, 12'h244, 32'h0, r, s);
    check(32'(s), 32'd0, "R9 no stall");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule